// File: doc/BRIEF.md
# Serial GPIO Interrupt Event Unit

This block keeps one small control word for each channel of a serial GPIO controller and turns changes of a channel's sampled input into latched interrupt events. Software writes control words through a simple one-cycle write port. A second update path applies input level changes that arrive from the pins. Both paths share one update stage. That stage stores the new word, compares the old and new input bits, and decides whether the channel's selected trigger condition has fired.

Latched events sit in a packed status array that is read one 32-bit word at a time. An event is acknowledged by writing the channel's control word with its clear flag set. A single interrupt line is high while any event is pending. A one-cycle strobe marks every channel whose output bit was changed by an update.

Top module: `sgpio_irq_unit`

## Requirements
- R1: The control word is 7 bits: bit 0 input value, bit 1 output value, bit 2 interrupt enable, bits 5:3 trigger code, bit 6 clear flag. A write stores bits 5:0 and always stores bit 6 as zero. A control read returns the stored word in bits 6:0, with the upper bits zero.
- R2: Trigger codes are 000 falling edge, 001 rising edge, 010 level low and 011 level high. Any code with bit 2 set means both edges, whatever the lower bits hold.
- R3: An update whose new word has the enable bit clear never sets a status bit. The enable bit and trigger code are taken from the new word.
- R4: A trigger is evaluated only when the update changes the input bit. An update that leaves the input bit unchanged sets no status bit, in level modes as well.
- R5: An update with the clear flag set clears that channel's status bit whether or not it was set. If the same update also fires the trigger, the bit ends up set.
- R6: Channel n's status sits in status word n/32, at bit n%32. A read with rd_sel_i=1 returns the status word at rd_idx_i. A read with rd_sel_i=0 returns the control word at rd_idx_i.
- R7: irq_o is high exactly while at least one status bit is set. It follows the status from the same clock edge that applies an update.
- R8: An update that changes a channel's output bit raises that channel's bit of out_chg_o for exactly one cycle after the edge.
- R9: A status read with an index of 8 or more returns zero, and so does a control read with an index of 256 or more. A software write with an index of 256 or more changes nothing.
- R10: A pin update replaces only the input bit of the channel's stored word and goes through the same evaluation as a software write. A valid software write in the same cycle takes priority, and the pin update is dropped.
- R11: After reset, all control words, all status bits, irq_o, out_chg_o and rd_data_o are zero. Read data appears after the clock edge that follows the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software control-word write strobe |
| wr_idx_i | input | 9 | Channel index of the write |
| wr_data_i | input | 7 | Control word to write |
| pin_en_i | input | 1 | Pin level update strobe |
| pin_idx_i | input | 8 | Channel index of the pin update |
| pin_level_i | input | 1 | New input level for the pin update |
| rd_sel_i | input | 1 | Read source: 0 control word, 1 status word |
| rd_idx_i | input | 9 | Read index |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Aggregate interrupt |
| out_chg_o | output | 256 | Per-channel output-change strobe |

## Verification
The hardest case to reach is an update that clears a pending bit and, in the same write, fires the trigger again. To get there, the stimulus first latches an event on a channel, then moves the input back without effect while the bit is still pending, and finally writes the clear flag together with a fresh rising input. A table walks every trigger code through matching and non-matching input transitions, with each pending bit cleared in between. This shows that enable gating and the both-edges override act from the word being written. Directed steps cover the pin path, the write-versus-pin priority, unchanged-input level writes and out-of-range indices.

// File: rtl/sgpio_irq_pkg.sv
package sgpio_irq_pkg;
  localparam int CW_W = 7;

  typedef struct packed {
    logic       clr;    // bit 6, never stored
    logic [2:0] trig;   // bits 5:3
    logic       en;     // bit 2
    logic       out_v;  // bit 1
    logic       in_v;   // bit 0
  } ctrl_t;

  localparam logic [1:0] TRG_FALL = 2'd0;
  localparam logic [1:0] TRG_RISE = 2'd1;
  localparam logic [1:0] TRG_LOW  = 2'd2;
  localparam logic [1:0] TRG_HIGH = 2'd3;
endpackage

// File: rtl/sgpio_trig_eval.sv
module sgpio_trig_eval
  import sgpio_irq_pkg::*;
(
  input  logic       en_i,
  input  logic [2:0] trig_i,
  input  logic       old_i,
  input  logic       new_i,
  output logic       hit_o
);
  logic rise, fall, cond;

  assign rise = new_i & ~old_i;
  assign fall = old_i & ~new_i;

  always_comb begin
    if (trig_i[2]) cond = rise | fall;  // both edges, low bits ignored
    else begin
      unique case (trig_i[1:0])
        TRG_FALL: cond = fall;
        TRG_RISE: cond = rise;
        TRG_LOW:  cond = ~new_i;
        default:  cond = new_i;
      endcase
    end
  end

  // level modes also need an input change
  assign hit_o = en_i & (old_i ^ new_i) & cond;
endmodule

// File: rtl/sgpio_status_bank.sv
module sgpio_status_bank #(
  parameter int NUM_CH = 256,
  parameter int WORD_W = 32,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int NUM_WORDS = NUM_CH / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [CH_W-1:0]   idx_i,
  input  logic              clr_i,
  input  logic              hit_i,
  output logic [NUM_CH-1:0] status_o,
  output logic              irq_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic              sel;
    logic [WORD_W-1:0] word_n;
    assign sel = upd_i && (idx_i[CH_W-1:BIT_W] == (CH_W-BIT_W)'(w));

    always_comb begin
      word_n = word_q[w];
      if (sel && clr_i) word_n[idx_i[BIT_W-1:0]] = 1'b0;
      if (sel && hit_i) word_n[idx_i[BIT_W-1:0]] = 1'b1;  // event after clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[w] <= '0;
      else         word_q[w] <= word_n;
    end
  end

  assign status_o = word_q;
  assign irq_o    = |word_q;

  p_clear_sticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && clr_i && !hit_i |=> !status_o[$past(idx_i)]);
  p_hit_latches_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && hit_i |=> status_o[$past(idx_i)] && irq_o);
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(status_o));
endmodule

// File: rtl/sgpio_irq_unit.sv
module sgpio_irq_unit
  import sgpio_irq_pkg::*;
#(
  parameter int NUM_CH = 256,
  parameter int WORD_W = 32,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int IDX_W     = CH_W + 1,
  localparam int NUM_WORDS = NUM_CH / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CW_W-1:0]   wr_data_i,
  input  logic              pin_en_i,
  input  logic [CH_W-1:0]   pin_idx_i,
  input  logic              pin_level_i,
  input  logic              rd_sel_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] out_chg_o
);
  ctrl_t ctrl_q [NUM_CH];
  ctrl_t old_w, new_w, store_w;
  logic  wr_ok, upd, hit;
  logic [CH_W-1:0] upd_idx;
  logic [NUM_CH-1:0] status;
  logic [NUM_WORDS-1:0][WORD_W-1:0] status_w;
  logic [NUM_CH-1:0] chg_n, chg_q;
  logic [WORD_W-1:0] rd_q;

  // shared update stage: software write wins over pin update
  assign wr_ok   = wr_en_i && (wr_idx_i < IDX_W'(NUM_CH));
  assign upd     = wr_ok || pin_en_i;
  assign upd_idx = wr_ok ? wr_idx_i[CH_W-1:0] : pin_idx_i;
  assign old_w   = ctrl_q[upd_idx];

  always_comb begin
    if (wr_ok) new_w = ctrl_t'(wr_data_i);
    else begin
      new_w      = old_w;
      new_w.in_v = pin_level_i;
    end
    store_w     = new_w;
    store_w.clr = 1'b0;
  end

  sgpio_trig_eval u_eval (
    .en_i  (new_w.en),
    .trig_i(new_w.trig),
    .old_i (old_w.in_v),
    .new_i (new_w.in_v),
    .hit_o (hit)
  );

  sgpio_status_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .idx_i   (upd_idx),
    .clr_i   (new_w.clr),
    .hit_i   (upd && hit),
    .status_o(status),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) ctrl_q[i] <= '0;
    end else if (upd) begin
      ctrl_q[upd_idx] <= store_w;
    end
  end

  always_comb begin
    chg_n = '0;
    if (upd && (old_w.out_v != new_w.out_v)) chg_n[upd_idx] = 1'b1;
  end

  assign status_w = status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= '0;
      rd_q  <= '0;
    end else begin
      chg_q <= chg_n;
      if (rd_sel_i)
        rd_q <= (rd_idx_i < IDX_W'(NUM_WORDS)) ? status_w[rd_idx_i[$clog2(NUM_WORDS)-1:0]] : '0;
      else
        rd_q <= (rd_idx_i < IDX_W'(NUM_CH))
                ? WORD_W'(ctrl_q[rd_idx_i[CH_W-1:0]]) : '0;
    end
  end

  assign out_chg_o = chg_q;
  assign rd_data_o = rd_q;

  p_disabled_no_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && !new_w.en && !new_w.clr |=> $stable(status));
  p_same_input_no_eval_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && (old_w.in_v == new_w.in_v) && !new_w.clr |=> $stable(status));
  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_chg_o));
  p_oob_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_idx_i >= IDX_W'(NUM_CH)) && !pin_en_i |=> $stable(status) && $stable(irq_o));
endmodule

// File: tb/sim_sgpio_irq_unit.sv
module sim_sgpio_irq_unit;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pin_en = 0, pin_level = 0, rd_sel = 0;
  logic [8:0] wr_idx = 0, rd_idx = 0;
  logic [6:0] wr_data = 0;
  logic [7:0] pin_idx = 0;
  logic [31:0] rd_data;
  logic irq;
  logic [255:0] out_chg;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sgpio_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .pin_en_i(pin_en), .pin_idx_i(pin_idx),
    .pin_level_i(pin_level), .rd_sel_i(rd_sel), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .irq_o(irq), .out_chg_o(out_chg)
  );

  // {trig[2:0], en, old_in, new_in, expected}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    7'b000_1_10_1, 7'b000_1_01_0, 7'b001_1_01_1, 7'b001_1_10_0,
    7'b010_1_10_1, 7'b010_1_01_0, 7'b011_1_01_1, 7'b011_1_10_0,
    7'b100_1_01_1, 7'b111_1_10_1, 7'b110_1_01_1, 7'b001_0_01_0,
    7'b011_0_01_0
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(int idx, logic [6:0] d);
    wr_en = 1; wr_idx = 9'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pin(int idx, logic lvl);
    pin_en = 1; pin_idx = 8'(idx); pin_level = lvl;
    @(negedge clk);
    pin_en = 0;
  endtask

  task automatic rd(logic sel, int idx, output logic [31:0] d);
    rd_sel = sel; rd_idx = 9'(idx);
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R11 strobe", 32'(out_chg != 0), 0);
    chk("R11 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    rd(0, 0, d); chk("R11 ctrl0", d, 0);
    rd(1, 3, d); chk("R11 status3", d, 0);

    // R2 R3 table walk
    for (int i = 0; i < NV; i++) begin
      automatic int ch = i * 19 + 3;
      automatic logic [2:0] tg = VEC[i][6:4];
      wr(ch, {1'b0, tg, 1'b0, 1'b0, VEC[i][2]});
      wr(ch, {1'b0, tg, VEC[i][3], 1'b0, VEC[i][1]});
      chk("R7 irq follows event", 32'(irq), 32'(VEC[i][0]));
      rd(1, ch / 32, d);
      chk("R2 R3 status bit", 32'(d[ch % 32]), 32'(VEC[i][0]));
      rd(0, ch, d);
      chk("R1 stored word", d, {25'b0, 1'b0, tg, VEC[i][3], 1'b0, VEC[i][1]});
      wr(ch, {1'b1, tg, 1'b0, 1'b0, VEC[i][1]});
      chk("R5 cleared", 32'(irq), 0);
    end

    // R1 clear flag not stored
    wr(2, 7'b1_000_0_0_0);
    rd(0, 2, d); chk("R1 clear flag masked", d, 0);

    // R8 output strobe
    wr(5, 7'b0_000_0_1_0);
    chk("R8 strobe on", 32'(out_chg == (256'b1 << 5)), 1);
    @(negedge clk);
    chk("R8 strobe one cycle", 32'(out_chg != 0), 0);
    wr(5, 7'b0_000_0_1_0);
    chk("R8 no strobe when unchanged", 32'(out_chg != 0), 0);

    // R5 clear and new event in one write
    wr(10, 7'b0_001_1_0_1);
    chk("R5 pending", 32'(irq), 1);
    wr(10, 7'b0_001_1_0_0);
    wr(10, 7'b1_001_1_0_1);
    rd(1, 0, d); chk("R5 clear then set", 32'(d[10]), 1);
    wr(10, 7'b1_001_1_0_1);
    rd(1, 0, d); chk("R5 clear only", 32'(d[10]), 0);
    chk("R7 irq low", 32'(irq), 0);
    wr(11, 7'b1_001_1_0_0);
    rd(1, 0, d); chk("R5 clear when not pending", 32'(d[11]), 0);

    // R4 level mode without input change
    wr(20, 7'b0_011_0_0_1);
    wr(20, 7'b0_011_1_0_1);
    rd(1, 0, d); chk("R4 no eval on same input", 32'(d[20]), 0);
    chk("R4 irq", 32'(irq), 0);

    // R10 pin path
    wr(40, 7'b0_001_1_0_0);
    pin(40, 1);
    chk("R10 pin event irq", 32'(irq), 1);
    rd(1, 1, d); chk("R10 pin status", d, 32'h0000_0100);
    rd(0, 40, d); chk("R10 pin keeps fields", d, 32'b0001101);
    wr(40, 7'b1_001_1_0_1);
    pin(40, 1);
    chk("R10 R4 pin same level", 32'(irq), 0);
    wr(42, 7'b0_001_1_0_0);
    wr_en = 1; wr_idx = 41; wr_data = 0;
    pin_en = 1; pin_idx = 42; pin_level = 1;
    @(negedge clk);
    wr_en = 0; pin_en = 0;
    rd(0, 42, d); chk("R10 write priority", d, 32'b0001100);
    chk("R10 no event", 32'(irq), 0);

    // R6 packing, R9 out of range
    wr(255, 7'b0_001_1_0_1);
    rd(1, 7, d); chk("R6 top channel", d, 32'h8000_0000);
    rd(1, 8, d); chk("R9 status oob read", d, 0);
    rd(0, 300, d); chk("R9 ctrl oob read", d, 0);
    wr(256, 7'h7F);
    rd(0, 0, d); chk("R9 oob write ignored", d, 0);
    chk("R9 irq kept", 32'(irq), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule